// File: doc/BRIEF.md
# Parallel CRC-32 Fold Engine

This block reduces a long byte stream to a 128-bit value that is congruent, modulo the MSB-first CRC-32 generator 0x104C11DB7, to the message polynomial. It never steps bit by bit. It keeps four 128-bit lane accumulators. On each 64-byte beat, every lane is shifted forward by 512 bit positions at once. The shift uses two 64x64 carry-less products with precomputed remainders of powers of x. The product sum is then XORed with the lane's quarter of the new beat.

After the final 64-byte beat, a short merge sequence folds the four lanes into one. Up to three trailing 16-byte beats arrive on a side channel and are folded into that single value. The result is offered on a valid/ready output to a separate stage, which reduces it to 32 bits and applies the final inversion. A start pulse opens each message and captures the seed (normally all ones). Each message holds at least 64 bytes and is a whole number of 16-byte units.

Top module: `crc_fold_engine`

## Requirements
- R1: After reset and before any start pulse, in_ready, tail_ready and out_valid are low, and traffic on either input channel is ignored.
- R2: A start pulse captures init_crc as the seed. From the next cycle in_ready is high and tail_ready and out_valid are low.
- R3: The first accepted 64-byte beat is loaded into the four lanes with no folding. Lane k takes in_data[511-128k -: 128], so byte 0 in in_data[511:504] is the highest-order coefficient. The seed is XORed into bits 127:96 of lane 0.
- R4: Each later accepted 64-byte beat replaces every lane with hi*R1 ^ lo*R2 ^ slice. Here hi and lo are the lane's bits 127:64 and 63:0, R1 = 0x08833794C and R2 = 0x0E6228B11.
- R5: Every product is the 127-bit carry-less (GF(2)) product of two 64-bit operands, zero-extended to 128 bits.
- R6: The beat accepted with in_last high is followed by exactly three merge cycles, with in_ready low. In each merge cycle, lane 0 becomes hi*R3 ^ lo*R4 ^ lane j, with j = 1, then 2, then 3. R3 = 0x0C5B9CD4C and R4 = 0x0E8A45605.
- R7: in_tails, sampled with the last beat, gives the number of 16-byte tail beats (0 to 3). tail_ready is high only while tail beats are still owed. Each accepted tail_data folds into lane 0 with R3/R4 in the same way.
- R8: When merging and tails are done, out_valid rises with out_data equal to lane 0. Both hold steady until out_ready is high, and after that handshake the block returns to the idle state of R1.
- R9: out_data reduced modulo 0x104C11DB7 equals the reduced message polynomial. The message polynomial is all accepted bytes in order, MSB-first, with the seed XORed onto the first four bytes.
- R10: A start pulse in any phase, including while a result waits, abandons the current message and begins a new one as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new message and captures the seed |
| init_crc | input | 32 | Seed value, sampled with start |
| in_valid | input | 1 | 64-byte beat offered |
| in_ready | output | 1 | 64-byte beat can be accepted |
| in_data | input | 512 | 64-byte beat, first byte in bits 511:504 |
| in_last | input | 1 | Marks the final 64-byte beat |
| in_tails | input | TAIL_CNT_W | Number of 16-byte tail beats to follow, valid with in_last |
| tail_valid | input | 1 | 16-byte tail beat offered |
| tail_ready | output | 1 | Tail beat can be accepted |
| tail_data | input | 128 | 16-byte tail beat, first byte in bits 127:120 |
| out_valid | output | 1 | Folded result available |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Folded 128-bit result |

## Verification
A wrong product or constant in any lane stays invisible at the ports until the merge is over. It then shows up as a wrong out_data word in the first cycle that out_valid is high. The modular check against a bit-serial division catches it even when the exact-value model shares the same mistake. A fault in the sequencing shows within one cycle as a wrong level on in_ready, tail_ready or out_valid. Examples are a merge that runs too short, a lost tail count, or a start that fails to cut off a message. Each of these is compared against the bench model on every clock.

// File: rtl/crc_fold_pkg.sv
`timescale 1ns/1ps
package crc_fold_pkg;
  localparam int LANE_W  = 128;
  localparam int HALF_W  = LANE_W / 2;
  localparam int N_LANES = 4;
  localparam int BEAT_W  = N_LANES * LANE_W;
  localparam int SEED_W  = 32;
  localparam int SEL_W   = $clog2(N_LANES);

  // shift-forward remainders for a four-lane stride and a one-lane stride
  localparam logic [HALF_W-1:0] K_R1 = 64'h0_8833_794C;
  localparam logic [HALF_W-1:0] K_R2 = 64'h0_E622_8B11;
  localparam logic [HALF_W-1:0] K_R3 = 64'h0_C5B9_CD4C;
  localparam logic [HALF_W-1:0] K_R4 = 64'h0_E8A4_5605;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_BULK, ST_MERGE, ST_TAIL, ST_DONE
  } phase_e;

  // GF(2) product of two half-width words, zero-extended
  function automatic lane_t clmul(input logic [HALF_W-1:0] a,
                                  input logic [HALF_W-1:0] b);
    lane_t acc;
    acc = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (a[i]) acc = acc ^ (lane_t'(b) << i);
    end
    return acc;
  endfunction

  function automatic lane_t fold_lane(input lane_t v,
                                      input logic [HALF_W-1:0] k_hi,
                                      input logic [HALF_W-1:0] k_lo,
                                      input lane_t addend);
    return clmul(v[LANE_W-1:HALF_W], k_hi) ^ clmul(v[HALF_W-1:0], k_lo) ^ addend;
  endfunction
endpackage

// File: rtl/crc_fold_unit.sv
`timescale 1ns/1ps
module crc_fold_unit
  import crc_fold_pkg::*;
#(
  parameter logic [HALF_W-1:0] K_HI = '0,
  parameter logic [HALF_W-1:0] K_LO = '0
) (
  input  lane_t acc_i,
  input  lane_t add_i,
  output lane_t nxt_o
);
  assign nxt_o = fold_lane(acc_i, K_HI, K_LO, add_i);
endmodule

// File: rtl/crc_fold_ctrl.sv
`timescale 1ns/1ps
module crc_fold_ctrl
  import crc_fold_pkg::*;
#(
  parameter int TAIL_CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  in_valid,
  input  logic                  in_last,
  input  logic [TAIL_CNT_W-1:0] in_tails,
  input  logic                  tail_valid,
  input  logic                  out_ready,
  output logic                  in_ready,
  output logic                  tail_ready,
  output logic                  out_valid,
  output logic                  load_first,
  output logic                  fold_bulk,
  output logic                  merge_step,
  output logic [SEL_W-1:0]      merge_sel,
  output logic                  tail_fold
);
  phase_e                state;
  logic [SEL_W-1:0]      merge_cnt;
  logic [TAIL_CNT_W-1:0] tails_left;

  logic in_fire, last_accept, merge_last, tail_final, out_fire;

  assign in_ready   = (state == ST_FIRST) || (state == ST_BULK);
  assign tail_ready = (state == ST_TAIL);
  assign out_valid  = (state == ST_DONE);

  assign in_fire     = in_valid && in_ready && !start;
  assign last_accept = in_fire && in_last;
  assign load_first  = in_fire && (state == ST_FIRST);
  assign fold_bulk   = in_fire && (state == ST_BULK);
  assign merge_step  = (state == ST_MERGE) && !start;
  assign merge_last  = (merge_cnt == SEL_W'(N_LANES - 2));
  assign merge_sel   = SEL_W'(merge_cnt + 1'b1);
  assign tail_fold   = tail_valid && tail_ready && !start;
  assign tail_final  = tail_fold && (tails_left == TAIL_CNT_W'(1));
  assign out_fire    = out_valid && out_ready && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      merge_cnt  <= '0;
      tails_left <= '0;
    end else if (start) begin
      state      <= ST_FIRST;
      merge_cnt  <= '0;
      tails_left <= '0;
    end else begin
      case (state)
        ST_FIRST, ST_BULK: begin
          if (in_valid) begin
            if (in_last) begin
              state      <= ST_MERGE;
              tails_left <= in_tails;
              merge_cnt  <= '0;
            end else begin
              state <= ST_BULK;
            end
          end
        end
        ST_MERGE: begin
          merge_cnt <= merge_cnt + 1'b1;
          if (merge_last) state <= (tails_left == '0) ? ST_DONE : ST_TAIL;
        end
        ST_TAIL: begin
          if (tail_valid) begin
            tails_left <= tails_left - 1'b1;
            if (tail_final) state <= ST_DONE;
          end
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a start pulse opens the first-beat phase on the next cycle
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (in_ready && !tail_ready && !out_valid));

  // R6: no tail or result phase within three cycles of the last beat
  p_merge_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_ready || out_valid) |->
      (!$past(last_accept, 1) && !$past(last_accept, 2) && !$past(last_accept, 3)));

  // R7: the final owed tail leads straight to the result
  p_tail_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_final && !start) |=> out_valid);

  // R8: after the output handshake the block is idle
  p_back_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> (!in_ready && !tail_ready && !out_valid));
endmodule

// File: rtl/crc_fold_engine.sv
`timescale 1ns/1ps
module crc_fold_engine
  import crc_fold_pkg::*;
#(
  parameter int TAIL_CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SEED_W-1:0]     init_crc,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BEAT_W-1:0]     in_data,
  input  logic                  in_last,
  input  logic [TAIL_CNT_W-1:0] in_tails,
  input  logic                  tail_valid,
  output logic                  tail_ready,
  input  logic [LANE_W-1:0]     tail_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANE_W-1:0]     out_data
);
  lane_t             lane_q    [N_LANES];
  lane_t             slice     [N_LANES];
  lane_t             first_val [N_LANES];
  lane_t             bulk_nxt  [N_LANES];
  lane_t             merge_add;
  lane_t             merge_nxt;
  logic [SEED_W-1:0] seed_q;

  logic             load_first, fold_bulk, merge_step, tail_fold;
  logic [SEL_W-1:0] merge_sel;

  crc_fold_ctrl #(.TAIL_CNT_W(TAIL_CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_tails   (in_tails),
    .tail_valid (tail_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .tail_ready (tail_ready),
    .out_valid  (out_valid),
    .load_first (load_first),
    .fold_bulk  (fold_bulk),
    .merge_step (merge_step),
    .merge_sel  (merge_sel),
    .tail_fold  (tail_fold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seed_q <= '0;
    else if (start) seed_q <= init_crc;
  end

  // one multiplier pair per lane for the four-lane stride
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign slice[g] = in_data[BEAT_W-1-g*LANE_W -: LANE_W];

    if (g == 0) begin : g_seeded
      assign first_val[g] = slice[g] ^ {seed_q, {(LANE_W-SEED_W){1'b0}}};
    end else begin : g_plain
      assign first_val[g] = slice[g];
    end

    crc_fold_unit #(.K_HI(K_R1), .K_LO(K_R2)) u_bulk (
      .acc_i (lane_q[g]),
      .add_i (slice[g]),
      .nxt_o (bulk_nxt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lane_q[g] <= '0;
      else if (start)                              lane_q[g] <= '0;
      else if (load_first)                         lane_q[g] <= first_val[g];
      else if (fold_bulk)                          lane_q[g] <= bulk_nxt[g];
      else if (g == 0 && (merge_step || tail_fold)) lane_q[g] <= merge_nxt;
    end
  end

  // shared one-lane-stride unit for the merge steps and the tail beats
  assign merge_add = merge_step ? lane_q[merge_sel] : tail_data;

  crc_fold_unit #(.K_HI(K_R3), .K_LO(K_R4)) u_merge (
    .acc_i (lane_q[0]),
    .add_i (merge_add),
    .nxt_o (merge_nxt)
  );

  assign out_data = lane_q[0];

  // R8: an unclaimed result stays put
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  // R3: the first beat lands in lane 0 with the seed on its top word
  p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_first && !start) |=>
      (lane_q[0] == ($past(in_data[BEAT_W-1 -: LANE_W]) ^ {$past(seed_q), {(LANE_W-SEED_W){1'b0}}})));

  // R10: a start pulse empties the result word
  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (out_data == '0));
endmodule

// File: tb/crc_fold_engine_tb.sv
`timescale 1ns/1ps
module crc_fold_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  init_crc = '0;
  logic         in_valid = 1'b0;
  logic [511:0] in_data = '0;
  logic         in_last = 1'b0;
  logic [1:0]   in_tails = '0;
  logic         tail_valid = 1'b0;
  logic [127:0] tail_data = '0;
  logic         out_ready = 1'b0;
  logic         in_ready, tail_ready, out_valid;
  logic [127:0] out_data;

  crc_fold_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .init_crc(init_crc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_tails(in_tails),
    .tail_valid(tail_valid), .tail_ready(tail_ready), .tail_data(tail_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  localparam logic [63:0] C1 = 64'h8833794C;
  localparam logic [63:0] C2 = 64'hE6228B11;
  localparam logic [63:0] C3 = 64'hC5B9CD4C;
  localparam logic [63:0] C4 = 64'hE8A45605;

  int           mst = 0;   // 0 idle,1 first,2 bulk,3 merge,4 tail,5 done
  int           mk = 0;
  int           mtails = 0;
  logic [31:0]  mseed = '0;
  logic [127:0] ml [4];
  byte unsigned msg [$];
  bit           cong_done = 0;

  function automatic logic [127:0] m_clmul(logic [63:0] a, logic [63:0] b);
    logic [127:0] acc = '0;
    logic [127:0] sh = {64'b0, a};
    for (int j = 0; j < 64; j++) begin
      if (b[j]) acc ^= sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  function automatic logic [127:0] m_fold(logic [127:0] v, logic [63:0] kh, logic [63:0] kl);
    return m_clmul(v[127:64], kh) ^ m_clmul(v[63:0], kl);
  endfunction

  function automatic logic [31:0] shift_bit(logic [31:0] r, logic b);
    logic top = r[31];
    logic [31:0] n = {r[30:0], b};
    if (top) n ^= 32'h04C11DB7;
    return n;
  endfunction

  function automatic logic [31:0] rem_msg();
    logic [31:0] r = '0;
    foreach (msg[i]) for (int k = 7; k >= 0; k--) r = shift_bit(r, msg[i][k]);
    return r;
  endfunction

  function automatic logic [31:0] rem_word(logic [127:0] v);
    logic [31:0] r = '0;
    for (int k = 127; k >= 0; k--) r = shift_bit(r, v[k]);
    return r;
  endfunction

  task automatic record_beat(logic [511:0] d, bit first);
    for (int k = 0; k < 64; k++) begin
      byte unsigned b = d[511-8*k -: 8];
      if (first && k < 4) b ^= mseed[31-8*k -: 8];
      msg.push_back(b);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0;
    end else if (start) begin
      mst = 1; mseed = init_crc; cong_done = 0; msg.delete();
      for (int i = 0; i < 4; i++) ml[i] = '0;
    end else begin
      case (mst)
        1, 2: if (in_valid) begin
          for (int i = 0; i < 4; i++) begin
            if (mst == 1) ml[i] = in_data[511-128*i -: 128];
            else ml[i] = m_fold(ml[i], C1, C2) ^ in_data[511-128*i -: 128];
          end
          if (mst == 1) ml[0][127:96] ^= mseed;
          record_beat(in_data, mst == 1);
          if (in_last) begin mst = 3; mk = 0; mtails = in_tails; end
          else mst = 2;
        end
        3: begin
          ml[0] = m_fold(ml[0], C3, C4) ^ ml[mk+1];
          mk++;
          if (mk == 3) mst = (mtails == 0) ? 5 : 4;
        end
        4: if (tail_valid) begin
          ml[0] = m_fold(ml[0], C3, C4) ^ tail_data;
          for (int k = 0; k < 16; k++) msg.push_back(tail_data[127-8*k -: 8]);
          mtails--;
          if (mtails == 0) mst = 5;
        end
        5: if (out_ready) mst = 0;
        default: mst = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2/R6/R10 in_ready", {127'b0, in_ready}, {127'b0, (mst == 1 || mst == 2)});
      chk("R7 tail_ready", {127'b0, tail_ready}, {127'b0, (mst == 4)});
      chk("R8 out_valid", {127'b0, out_valid}, {127'b0, (mst == 5)});
      if (mst == 5) begin
        // R3/R4/R5/R6/R7 exact folded value
        chk("R3/R4/R5/R6/R7 out_data", out_data, ml[0]);
        if (!cong_done) begin
          chk("R9/R10 residue", {96'b0, rem_word(out_data)}, {96'b0, rem_msg()});
          cong_done = 1;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start(logic [31:0] seed);
    start = 1; init_crc = seed; tick(); start = 0;
  endtask

  task automatic send_beat(logic [511:0] d, bit last, logic [1:0] tails, int gap);
    bit ok;
    repeat (gap) tick();
    in_valid = 1; in_data = d; in_last = last; in_tails = tails;
    do begin @(negedge clk); ok = in_ready; @(posedge clk); #1; end while (!ok);
    in_valid = 0; in_last = 0; in_data = '0;
  endtask

  task automatic send_tail(logic [127:0] d, int gap);
    bit ok;
    repeat (gap) tick();
    tail_valid = 1; tail_data = d;
    do begin @(negedge clk); ok = tail_ready; @(posedge clk); #1; end while (!ok);
    tail_valid = 0; tail_data = '0;
  endtask

  task automatic take_out(int hold);
    bit ok;
    repeat (hold) tick();
    out_ready = 1;
    do begin @(negedge clk); ok = out_valid; @(posedge clk); #1; end while (!ok);
    out_ready = 0;
  endtask

  function automatic logic [511:0] rbeat();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [511:0] ramp_beat();
    logic [511:0] r;
    for (int k = 0; k < 64; k++) r[511-8*k -: 8] = 8'(k);
    return r;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1;
    // R1: idle after reset, stray traffic ignored
    in_valid = 1; tail_valid = 1; in_data = rbeat();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R1 idle flags", {125'b0, in_ready, tail_ready, out_valid}, '0);
      @(posedge clk); #1;
    end
    in_valid = 0; tail_valid = 0; in_data = '0;

    // single beat, all-ones seed, result held before the take
    do_start(32'hFFFFFFFF);
    @(negedge clk);
    chk("R2 ready after start", {127'b0, in_ready}, 128'd1);
    @(posedge clk); #1;
    send_beat(ramp_beat(), 1, 2'd0, 0);
    take_out(4);

    // three beats, two tails, zero seed, bubbles
    do_start(32'h0);
    send_beat(rbeat(), 0, 2'd0, 1);
    send_beat(rbeat(), 0, 2'd0, 2);
    send_beat(rbeat(), 1, 2'd2, 0);
    send_tail({4{32'hA5A5_0F0F}}, 1);
    send_tail(rbeat()[127:0], 0);
    take_out(0);

    // two beats, three tails; stray tail during bulk, stray beat during merge
    do_start(32'h12345678);
    send_beat(rbeat(), 0, 2'd0, 0);
    tail_valid = 1; tail_data = '1; tick(); tail_valid = 0; tail_data = '0;
    send_beat(rbeat(), 1, 2'd3, 0);
    in_valid = 1; in_data = rbeat(); repeat (3) tick(); in_valid = 0; in_data = '0;
    send_tail(rbeat()[127:0], 2);
    send_tail(rbeat()[127:0], 0);
    send_tail(rbeat()[127:0], 1);
    take_out(1);

    // R10: abandon mid-bulk, then a four-beat message with one tail
    do_start(32'hDEADBEEF);
    send_beat(rbeat(), 0, 2'd0, 0);
    do_start(32'hFFFFFFFF);
    for (int b = 0; b < 4; b++) send_beat(rbeat(), b == 3, 2'd1, 0);
    send_tail(rbeat()[127:0], 0);
    take_out(0);

    // R10: restart while a result waits, then five zero beats and three tails
    do_start(32'h0BADF00D);
    send_beat(rbeat(), 1, 2'd0, 0);
    repeat (6) tick();
    do_start(32'hFFFFFFFF);
    for (int b = 0; b < 5; b++) send_beat('0, b == 4, 2'd3, 0);
    for (int t = 0; t < 3; t++) send_tail('0, t);
    take_out(2);

    repeat (3) tick();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule